// File: doc/BRIEF.md
# Debug Breakpoint Arbiter and Trace Session Controller

This block sits inside an on-chip debug unit and decides, every clock, which breakpoint request (if any) goes to the CPU and whether the current trace session keeps running. Its inputs are comparator channel hits, a comparator tag hit, two external tag pins, an auxiliary forced-break input, a coprocessor software break, a manual trigger, and three flags describing the CPU side: debug mode active, a debug trace command in progress, and a pending user software interrupt.

The block runs a three-state session sequencer. State 0 is disarmed. State 1 is armed and waiting for a trigger. State 2 is final, meaning triggered and counting trace entries. Software arms a session with a single write strobe. A trigger either ends the session at once or starts a post-trigger count, depending on the alignment setting. Several kinds of event end a session immediately, whatever the alignment: an external tag, the auxiliary input, or a coprocessor break. Every breakpoint output is a registered pulse. Forced requests take priority over tagged ones, and the outputs are masked while the CPU is already in debug mode.

Top module: `dbg_break_arb`

## Requirements
- R1: A high on `extTagHi` or `extTagLo` ends an armed session at the next clock edge, whatever the alignment. `seqState` returns to 0, `traceStop` pulses and `taggedBrk` pulses. Outside a session the tag still pulses `taggedBrk`.
- R2: `auxBrk` ends an armed session. It raises `forcedBrk` only while `brkEnable` is 1.
- R3: `copSwBrk` raises `forcedBrk` whatever the value of `brkEnable`, and ends any session. It wins over an external tag in the same cycle, so only `forcedBrk` pulses.
- R4: In state 2, later manual triggers and later channel hits are ignored. A break that was requested by the triggering channel (one whose enable bit is 1) is delivered when the session completes, and not before.
- R5: A manual trigger never raises a breakpoint itself. Once it has started begin-aligned tracing, a hit on a channel whose `chanBrkEn` bit is 0 has no effect.
- R6: A comparator tag hit together with an external tag hit returns the sequencer to state 0, even in begin or mid alignment.
- R7: When a forced request and a tagged request occur in the same cycle, only `forcedBrk` pulses.
- R8: While `dbgActive` is 1, no breakpoint pulse and no `swiTake` is produced. While `dbgTraceCmd` is 1, tagged breaks are suppressed but forced breaks still pass.
- R9: `swiTake` follows `userSwi` one cycle later, except in a cycle in which a breakpoint pulse is issued. The software interrupt is then taken on a later cycle while `userSwi` stays high.
- R10: `alignSel` encodes 00 as end, 01 as begin and 10 as mid; 11 behaves as end. In end alignment a trigger ends the session at once. In begin alignment `traceRun` is 0 until the trigger. In end and mid alignment `traceRun` is 1 throughout state 1.
- R11: On a trigger in begin or mid alignment, a counter loads `TRACE_DEPTH` (begin) or `midCount` (mid). Each `entryStb` in state 2 decrements it. The session ends on the first clock edge at which the counter is already 0.
- R12: After reset, `seqState` is 0 and all outputs are 0. `armWr` moves state 0 to 1. It is ignored in the other states, and also when it coincides with a terminating source. Outputs are registered, so a one-cycle input produces a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armWr | input | 1 | Software arm strobe |
| alignSel | input | 2 | Trace alignment: 00 end, 01 begin, 10 mid |
| midCount | input | CNT_W | Post-trigger entry count in mid alignment |
| chanHit | input | NCH | Comparator channel hits |
| chanBrkEn | input | NCH | Per-channel break enable |
| cmpTagHit | input | 1 | Comparator tag hit |
| extTagHi | input | 1 | External high tag pin hit |
| extTagLo | input | 1 | External low tag pin hit |
| auxBrk | input | 1 | Auxiliary forced-break input |
| brkEnable | input | 1 | Enables forced break from auxiliary input |
| copSwBrk | input | 1 | Coprocessor software breakpoint |
| manTrig | input | 1 | Manual trigger |
| entryStb | input | 1 | One trace entry stored |
| dbgActive | input | 1 | CPU executing in debug mode |
| dbgTraceCmd | input | 1 | Debug trace command running |
| userSwi | input | 1 | User software interrupt request |
| seqState | output | 2 | Sequencer state (0 disarmed, 1 waiting, 2 final) |
| traceRun | output | 1 | Trace capture running |
| traceStop | output | 1 | Session-end pulse |
| forcedBrk | output | 1 | Forced breakpoint pulse |
| taggedBrk | output | 1 | Tagged breakpoint pulse |
| swiTake | output | 1 | User software interrupt granted |

## Verification
The arbitration is exercised with several distinct patterns:
- Sources raised alone.
- Coincident pairs: forced with tagged, coprocessor with tag, comparator tag with external tag, and software interrupt with a breakpoint.
- The same late trigger presented both before and after a session has entered the final state.

The alone-versus-paired patterns show that the priority order holds, and not merely that each source works on its own. Each alignment mode is run through a complete session, with entry strobes both present and absent, so that the post-trigger count is seen to follow entries and not cycles. The masking flags are applied together with both forced and tagged sources, to show which kind each flag suppresses.

// File: rtl/dbg_break_pkg.sv
package dbg_break_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_FINAL = 2'd2
  } seqState_e;

  localparam logic [1:0] ALN_END   = 2'b00;
  localparam logic [1:0] ALN_BEGIN = 2'b01;
  localparam logic [1:0] ALN_MID   = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic loadMid;
    logic decCnt;
    logic reqForced;
    logic reqTagged;
    logic stopPulse;
  } dbgStb_t;

endpackage

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
  import dbg_break_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armWr,
  input  logic [1:0]        alignSel,
  input  logic [NCH-1:0]    chanHit,
  input  logic [NCH-1:0]    chanBrkEn,
  input  logic              cmpTagHit,
  input  logic              extTagHi,
  input  logic              extTagLo,
  input  logic              auxBrk,
  input  logic              brkEnable,
  input  logic              copSwBrk,
  input  logic              manTrig,
  input  logic              entryStb,
  input  logic              cntZero,
  output seqState_e         seqState,
  output logic              traceRun,
  output dbgStb_t           stb
);

  seqState_e stateQ, stateN;
  logic pendForcedQ, pendForcedN;
  logic pendTaggedQ, pendTaggedN;

  // per-channel gated break hits
  logic [NCH-1:0] brkHitVec;
  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : gChan
      assign brkHitVec[gi] = chanHit[gi] & chanBrkEn[gi];
    end
  endgenerate

  logic tagExt, immEnd, brkHit, anyTrig, endAlign;
  assign tagExt   = extTagHi | extTagLo;
  assign immEnd   = copSwBrk | tagExt | auxBrk;
  assign brkHit   = |brkHitVec;
  assign anyTrig  = manTrig | (|chanHit) | cmpTagHit;
  assign endAlign = (alignSel != ALN_BEGIN) && (alignSel != ALN_MID);

  always_comb begin
    stateN      = stateQ;
    pendForcedN = pendForcedQ;
    pendTaggedN = pendTaggedQ;
    stb           = '0;
    stb.reqForced = copSwBrk | (auxBrk & brkEnable);
    stb.reqTagged = tagExt;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (armWr && !immEnd) stateN = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (immEnd) begin
          stateN        = SEQ_IDLE;
          stb.stopPulse = 1'b1;
        end else if (anyTrig) begin
          if (endAlign) begin
            stateN        = SEQ_IDLE;
            stb.stopPulse = 1'b1;
            stb.reqForced = brkHit;
            stb.reqTagged = cmpTagHit;
          end else begin
            stateN      = SEQ_FINAL;
            stb.loadCnt = 1'b1;
            stb.loadMid = (alignSel == ALN_MID);
            pendForcedN = brkHit;
            pendTaggedN = cmpTagHit;
          end
        end
      end
      SEQ_FINAL: begin
        if (immEnd || cntZero) begin
          stateN        = SEQ_IDLE;
          stb.stopPulse = 1'b1;
          stb.reqForced = stb.reqForced | pendForcedQ;
          stb.reqTagged = stb.reqTagged | pendTaggedQ;
          pendForcedN   = 1'b0;
          pendTaggedN   = 1'b0;
        end else begin
          stb.decCnt = entryStb;
        end
      end
      default: stateN = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= SEQ_IDLE;
      pendForcedQ <= 1'b0;
      pendTaggedQ <= 1'b0;
    end else begin
      stateQ      <= stateN;
      pendForcedQ <= pendForcedN;
      pendTaggedQ <= pendTaggedN;
    end
  end

  assign seqState = stateQ;
  assign traceRun = (stateQ == SEQ_FINAL) ||
                    ((stateQ == SEQ_WAIT) && (alignSel != ALN_BEGIN));

  AST_EXT_TAG_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (extTagHi || extTagLo) |=> (stateQ == SEQ_IDLE)); // R1

  AST_FINAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_FINAL && !immEnd && !cntZero) |=> (stateQ == SEQ_FINAL)); // R4

  AST_TAG_PAIR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmpTagHit && tagExt) |=> (stateQ == SEQ_IDLE)); // R6

  AST_ARM_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != SEQ_IDLE) |=> (stateQ != SEQ_WAIT) || ($past(stateQ) == SEQ_WAIT)); // R12

endmodule

// File: rtl/dbg_break_dp.sv
module dbg_break_dp
  import dbg_break_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int TRACE_DEPTH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dbgStb_t          stb,
  input  logic [CNT_W-1:0] midCount,
  input  logic             dbgActive,
  input  logic             dbgTraceCmd,
  input  logic             userSwi,
  output logic             cntZero,
  output logic             traceStop,
  output logic             forcedBrk,
  output logic             taggedBrk,
  output logic             swiTake
);

  localparam logic [CNT_W-1:0] DEPTH_LD = CNT_W'(TRACE_DEPTH);

  logic [CNT_W-1:0] cntQ;
  logic forcedN, taggedN;

  // forced wins over tagged; debug mode masks both; trace command masks tags
  assign forcedN = stb.reqForced & ~dbgActive;
  assign taggedN = stb.reqTagged & ~stb.reqForced & ~dbgActive & ~dbgTraceCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      traceStop <= 1'b0;
      forcedBrk <= 1'b0;
      taggedBrk <= 1'b0;
      swiTake   <= 1'b0;
    end else begin
      if (stb.loadCnt)     cntQ <= stb.loadMid ? midCount : DEPTH_LD;
      else if (stb.decCnt) cntQ <= cntQ - 1'b1;
      traceStop <= stb.stopPulse;
      forcedBrk <= forcedN;
      taggedBrk <= taggedN;
      swiTake   <= userSwi & ~dbgActive & ~forcedN & ~taggedN;
    end
  end

  assign cntZero = (cntQ == '0);

  AST_DEBUG_MASK: assert property (@(posedge clk) disable iff (!rstN)
    dbgActive |=> (!forcedBrk && !taggedBrk && !swiTake)); // R8

  AST_SWI_YIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (forcedBrk || taggedBrk) |-> !swiTake); // R9

  AST_TRACECMD_TAG: assert property (@(posedge clk) disable iff (!rstN)
    dbgTraceCmd |=> !taggedBrk); // R8

endmodule

// File: rtl/dbg_break_arb.sv
module dbg_break_arb
  import dbg_break_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CNT_W       = 4,
  parameter int TRACE_DEPTH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armWr,
  input  logic [1:0]       alignSel,
  input  logic [CNT_W-1:0] midCount,
  input  logic [NCH-1:0]   chanHit,
  input  logic [NCH-1:0]   chanBrkEn,
  input  logic             cmpTagHit,
  input  logic             extTagHi,
  input  logic             extTagLo,
  input  logic             auxBrk,
  input  logic             brkEnable,
  input  logic             copSwBrk,
  input  logic             manTrig,
  input  logic             entryStb,
  input  logic             dbgActive,
  input  logic             dbgTraceCmd,
  input  logic             userSwi,
  output logic [1:0]       seqState,
  output logic             traceRun,
  output logic             traceStop,
  output logic             forcedBrk,
  output logic             taggedBrk,
  output logic             swiTake
);

  dbgStb_t   stb;
  seqState_e stateE;
  logic      cntZero;

  dbg_break_ctrl #(.NCH(NCH)) uCtrl (
    .clk(clk), .rstN(rstN), .armWr(armWr), .alignSel(alignSel),
    .chanHit(chanHit), .chanBrkEn(chanBrkEn), .cmpTagHit(cmpTagHit),
    .extTagHi(extTagHi), .extTagLo(extTagLo), .auxBrk(auxBrk),
    .brkEnable(brkEnable), .copSwBrk(copSwBrk), .manTrig(manTrig),
    .entryStb(entryStb), .cntZero(cntZero), .seqState(stateE),
    .traceRun(traceRun), .stb(stb)
  );

  dbg_break_dp #(.CNT_W(CNT_W), .TRACE_DEPTH(TRACE_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .midCount(midCount),
    .dbgActive(dbgActive), .dbgTraceCmd(dbgTraceCmd), .userSwi(userSwi),
    .cntZero(cntZero), .traceStop(traceStop), .forcedBrk(forcedBrk),
    .taggedBrk(taggedBrk), .swiTake(swiTake)
  );

  assign seqState = stateE;

  AST_COP_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    (copSwBrk && !dbgActive) |=> (forcedBrk && !taggedBrk)); // R3

  AST_AUX_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (auxBrk && !brkEnable && !copSwBrk && seqState == 2'd1) |=> !forcedBrk); // R2

  AST_FORCED_OVER_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (auxBrk && brkEnable && (extTagHi || extTagLo) && !dbgActive)
      |=> (forcedBrk && !taggedBrk)); // R7

endmodule

// File: tb/sim_dbg_break_arb.sv
module sim_dbg_break_arb;

  localparam int NCH = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armWr = 0, cmpTagHit = 0, extTagHi = 0, extTagLo = 0, auxBrk = 0;
  logic brkEnable = 0, copSwBrk = 0, manTrig = 0, entryStb = 0;
  logic dbgActive = 0, dbgTraceCmd = 0, userSwi = 0;
  logic [1:0] alignSel = 2'b00;
  logic [CNT_W-1:0] midCount = '0;
  logic [NCH-1:0] chanHit = '0, chanBrkEn = '0;
  logic [1:0] seqState;
  logic traceRun, traceStop, forcedBrk, taggedBrk, swiTake;

  always #4 clk = ~clk;

  dbg_break_arb #(.NCH(NCH), .CNT_W(CNT_W), .TRACE_DEPTH(6)) u0 (
    .clk(clk), .rstN(rstN), .armWr(armWr), .alignSel(alignSel),
    .midCount(midCount), .chanHit(chanHit), .chanBrkEn(chanBrkEn),
    .cmpTagHit(cmpTagHit), .extTagHi(extTagHi), .extTagLo(extTagLo),
    .auxBrk(auxBrk), .brkEnable(brkEnable), .copSwBrk(copSwBrk),
    .manTrig(manTrig), .entryStb(entryStb), .dbgActive(dbgActive),
    .dbgTraceCmd(dbgTraceCmd), .userSwi(userSwi), .seqState(seqState),
    .traceRun(traceRun), .traceStop(traceStop), .forcedBrk(forcedBrk),
    .taggedBrk(taggedBrk), .swiTake(swiTake)
  );

  typedef struct {
    string      tag;
    logic [6:0] val;  // {seqState, run, stop, forced, tagged, swi}
  } expItem_t;

  expItem_t expQ[$];
  int nCmp = 0;
  int nBad = 0;
  int cycles = 0;

  // driver: push expectation for the coming edge, then clear one-shot inputs
  task automatic cyc(input string tag, input logic [1:0] st, input logic run,
                     input logic stop, input logic f, input logic t, input logic swi);
    expItem_t e;
    e.tag = tag;
    e.val = {st, run, stop, f, t, swi};
    expQ.push_back(e);
    @(negedge clk);
    armWr = 0; chanHit = '0; cmpTagHit = 0; extTagHi = 0; extTagLo = 0;
    auxBrk = 0; copSwBrk = 0; manTrig = 0; entryStb = 0;
    dbgActive = 0; dbgTraceCmd = 0; userSwi = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        logic [6:0] got;
        e = expQ.pop_front();
        got = {seqState, traceRun, traceStop, forcedBrk, taggedBrk, swiTake};
        nCmp++;
        if (got !== e.val) begin
          nBad++;
          $display("FAIL %s: got st/run/stop/f/t/swi=%b expected %b", e.tag, got, e.val);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nBad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    cyc("R12 reset state", 2'd0, 0, 0, 0, 0, 0);

    // end alignment
    alignSel = 2'b00; chanBrkEn = 4'b0001;
    armWr = 1;      cyc("R12 arm", 2'd1, 1, 0, 0, 0, 0);
    armWr = 1;      cyc("R12 rearm ignored", 2'd1, 1, 0, 0, 0, 0);
    chanHit = 4'b0001; cyc("R10 end trigger", 2'd0, 0, 1, 1, 0, 0);
    cyc("R12 single pulse", 2'd0, 0, 0, 0, 0, 0);

    // begin alignment, manual trigger, depth 6
    alignSel = 2'b01;
    armWr = 1;   cyc("R10 begin waits idle", 2'd1, 0, 0, 0, 0, 0);
    manTrig = 1; cyc("R5 manual trigger", 2'd2, 1, 0, 0, 0, 0);
    entryStb = 1; chanHit = 4'b0010; cyc("R5 brkEn0 hit ignored", 2'd2, 1, 0, 0, 0, 0);
    entryStb = 1; chanHit = 4'b0001; cyc("R4 hit in final ignored", 2'd2, 1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      entryStb = 1; cyc("R11 begin count", 2'd2, 1, 0, 0, 0, 0);
    end
    cyc("R11 begin end no break", 2'd0, 0, 1, 0, 0, 0);

    // mid alignment, comparator trigger with break
    alignSel = 2'b10; midCount = 4'd2;
    armWr = 1;   cyc("R10 mid arm", 2'd1, 1, 0, 0, 0, 0);
    chanHit = 4'b0001; cyc("R4 comparator final", 2'd2, 1, 0, 0, 0, 0);
    manTrig = 1; cyc("R11 no entry holds", 2'd2, 1, 0, 0, 0, 0);
    entryStb = 1; cyc("R11 mid entry", 2'd2, 1, 0, 0, 0, 0);
    entryStb = 1; cyc("R11 mid entry", 2'd2, 1, 0, 0, 0, 0);
    cyc("R4 break at completion", 2'd0, 0, 1, 1, 0, 0);

    // external tags
    alignSel = 2'b01;
    armWr = 1;    cyc("R1 arm", 2'd1, 0, 0, 0, 0, 0);
    extTagLo = 1; cyc("R1 tag ends begin", 2'd0, 0, 1, 0, 1, 0);
    extTagHi = 1; cyc("R1 tag disarmed", 2'd0, 0, 0, 0, 1, 0);
    armWr = 1;    cyc("R6 arm", 2'd1, 0, 0, 0, 0, 0);
    cmpTagHit = 1; extTagHi = 1; cyc("R6 tag pair state0", 2'd0, 0, 1, 0, 1, 0);
    armWr = 1;    cyc("R6 arm", 2'd1, 0, 0, 0, 0, 0);
    cmpTagHit = 1; cyc("R6 cmp tag alone final", 2'd2, 1, 0, 0, 0, 0);
    extTagHi = 1; cyc("R1 tag ends final", 2'd0, 0, 1, 0, 1, 0);
    armWr = 1; extTagLo = 1; cyc("R12 arm with tag dropped", 2'd0, 0, 0, 0, 1, 0);

    // auxiliary and coprocessor
    alignSel = 2'b11; brkEnable = 0;
    armWr = 1;  cyc("R10 code 11 as end", 2'd1, 1, 0, 0, 0, 0);
    auxBrk = 1; cyc("R2 aux disabled", 2'd0, 0, 1, 0, 0, 0);
    brkEnable = 1;
    auxBrk = 1; cyc("R2 aux enabled", 2'd0, 0, 0, 1, 0, 0);
    auxBrk = 1; extTagHi = 1; cyc("R7 forced over tagged", 2'd0, 0, 0, 1, 0, 0);
    brkEnable = 0;
    armWr = 1;  cyc("R3 arm", 2'd1, 1, 0, 0, 0, 0);
    copSwBrk = 1; extTagLo = 1; cyc("R3 cop wins", 2'd0, 0, 1, 1, 0, 0);

    // masking
    dbgActive = 1; copSwBrk = 1; userSwi = 1; cyc("R8 debug masks", 2'd0, 0, 0, 0, 0, 0);
    dbgTraceCmd = 1; extTagHi = 1; cyc("R8 trace cmd masks tag", 2'd0, 0, 0, 0, 0, 0);
    brkEnable = 1;
    dbgTraceCmd = 1; auxBrk = 1; cyc("R8 trace cmd keeps forced", 2'd0, 0, 0, 1, 0, 0);

    // software interrupt
    userSwi = 1; cyc("R9 swi alone", 2'd0, 0, 0, 0, 0, 1);
    userSwi = 1; auxBrk = 1; cyc("R9 break wins", 2'd0, 0, 0, 1, 0, 0);
    userSwi = 1; cyc("R9 swi after", 2'd0, 0, 0, 0, 0, 1);
    userSwi = 1; extTagLo = 1; cyc("R9 tag wins", 2'd0, 0, 0, 0, 1, 0);
    cyc("R12 idle", 2'd0, 0, 0, 0, 0, 0);

    repeat (3) @(posedge clk);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule